// File: doc/BRIEF.md
# Error-Correcting Memory with Background Scrubber

This block is a single-port synchronous memory that protects every stored word with a single-error-correct, double-error-detect code. A user write encodes the data word and stores it together with its check bits, so each stored word is wider than the user data. A user read decodes the word as it leaves the array. A single flipped bit is corrected with no extra cycle of latency. Two flipped bits are reported as uncorrectable. An error-injection mask on the write path lets a test flip chosen bits of the stored codeword.

A scrub engine visits every address in turn. This stops isolated upsets from piling up into a double error. It may only use the memory in cycles where the user asserts neither read nor write. The engine is a three-state machine:
- **SC_OFF**: the engine is disabled. It moves to **SC_RD** once `scrub_en` is high.
- **SC_RD**: the engine issues a read of the current scrub address in the first idle cycle. It then moves to **SC_CHK**.
- **SC_CHK**: the decoded word is examined.
  - A clean or uncorrectable word advances the address.
  - A single error in a user-idle cycle writes the corrected codeword back and advances the address.
  - A single error that meets a user access abandons the write-back and keeps the address, so the word is read again later.
  - In every case the engine returns to **SC_RD**, or to **SC_OFF** when `scrub_en` is low.

Two saturating counters record corrected and uncorrectable events. A one-cycle pulse marks each uncorrectable detection.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A word written at an address is returned by a later read of that address. `usr_rvalid` is high in the cycle after the clock edge that samples `usr_re`. `usr_sec` and `usr_ded` are low for an unflipped word.
- R2: If exactly one codeword bit is flipped, the read returns the original data with `usr_sec` high and `usr_ded` low, at the same latency as R1. The codeword has DATA_W+P+1 bits. Bit k of `usr_inj` flips codeword bit k on a write. Bit 0 is the overall parity bit.
- R3: If two codeword bits are flipped, the read raises `usr_ded` with `usr_sec` low. `ue_pulse` is high for that one cycle.
- R4: When `usr_we` and `usr_re` are both high, only the write is performed and no read result follows.
- R5: The scrubber reads or writes the array only in cycles where `usr_we` and `usr_re` are both low. User reads are never disturbed by it.
- R6: With `scrub_en` high and the user idle, the scrubber walks all addresses in ascending order and wraps after the last. It rewrites each single-error word with corrected data, so a later read of that word is clean.
- R7: If a user access occurs in the cycle where a scrub write-back would happen, the write-back is dropped and the scrub address is kept for a retry.
- R8: With `scrub_en` low, no scrubbing takes place and stored errors remain.
- R9: `cnt_corr` counts corrected user reads plus scrub write-backs. `cnt_unc` counts uncorrectable detections. Both saturate at all ones.
- R10: After reset, `usr_rvalid`, `ue_pulse` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_we | input | 1 | User write enable |
| usr_re | input | 1 | User read enable |
| usr_addr | input | ADDR_W | User address |
| usr_wdata | input | DATA_W | User write data |
| usr_inj | input | CW_W | Bit mask XORed into the codeword on a user write |
| scrub_en | input | 1 | Enables the background scrubber |
| usr_rdata | output | DATA_W | Corrected read data |
| usr_rvalid | output | 1 | Read result valid |
| usr_sec | output | 1 | Read result had a corrected single error |
| usr_ded | output | 1 | Read result had an uncorrectable error |
| ue_pulse | output | 1 | One-cycle pulse per uncorrectable detection |
| cnt_corr | output | CNT_W | Saturating count of corrections |
| cnt_unc | output | CNT_W | Saturating count of uncorrectable detections |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=3 and CNT_W=4. Eight words mean a scrub pass takes only sixteen idle cycles, so full walks with wrap-around fit in short idle windows. A four-bit counter reaches saturation after fifteen corrections, so the R9 ceiling can be exercised directly. Alternating idle and busy cycles are applied so that every scrub check lands in a user-busy cycle, which makes the abandoned write-back of R7 observable through a later read.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

    typedef enum logic [1:0] {
        SC_OFF = 2'd0,
        SC_RD  = 2'd1,
        SC_CHK = 2'd2
    } scrub_state_t;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int ecc_hbits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < (dw + p + 1)) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ecc_scrub_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int P      = ecc_hbits(DATA_W),
    localparam int N      = DATA_W + P,
    localparam int CW_W   = N + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);

    // Positions 1..N carry the Hamming code; position 0 is overall parity.
    always_comb begin
        int  k;
        logic par;
        cw = '0;
        k  = 0;
        for (int j = 1; j <= N; j++) begin
            if ((j & (j - 1)) != 0) begin
                cw[j] = data[k];
                k++;
            end
        end
        for (int i = 0; i < P; i++) begin
            par = 1'b0;
            for (int j = 1; j <= N; j++) begin
                if ((((j >> i) & 1) == 1) && (j != (1 << i))) par = par ^ cw[j];
            end
            cw[1 << i] = par;
        end
        cw[0] = ^cw[N:1];
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ecc_scrub_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int P      = ecc_hbits(DATA_W),
    localparam int N      = DATA_W + P,
    localparam int CW_W   = N + 1
) (
    input  logic [CW_W-1:0]   cw_in,
    output logic [CW_W-1:0]   cw_fix,
    output logic [DATA_W-1:0] data,
    output logic              sec,
    output logic              ded
);

    logic [P-1:0] syn;
    logic         pe;

    // Syndrome tree: XOR of the positions of all set bits.
    always_comb begin
        syn = '0;
        for (int j = 1; j <= N; j++) begin
            if (cw_in[j]) syn = syn ^ P'(j);
        end
        pe = ^cw_in;
    end

    always_comb begin
        int k;
        cw_fix = cw_in;
        sec    = 1'b0;
        ded    = 1'b0;
        if (pe) begin
            if (int'(syn) <= N) begin
                cw_fix[syn] = ~cw_in[syn];
                sec         = 1'b1;
            end else begin
                ded = 1'b1;
            end
        end else if (syn != '0) begin
            ded = 1'b1;
        end
        data = '0;
        k    = 0;
        for (int j = 1; j <= N; j++) begin
            if ((j & (j - 1)) != 0) begin
                data[k] = cw_fix[j];
                k++;
            end
        end
    end

    // R3: a word cannot be both corrected and uncorrectable
    always_comb begin
        a_excl_r3: assert (!(sec && ded));
    end

endmodule

// File: rtl/ecc_ram_array.sv
module ecc_ram_array #(
    parameter  int W      = 22,
    parameter  int ADDR_W = 6,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      q
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (re && !we) q <= mem[addr];
    end

endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (inc && (q != '1)) q <= q + 1'b1;
    end

    // R9: count never decreases and never wraps
    p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q >= $past(q));

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import ecc_scrub_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic              usr_busy,
    input  logic              chk_sec,
    output logic              scr_rd,
    output logic              scr_wr,
    output logic              scr_chk,
    output logic [ADDR_W-1:0] scr_addr
);

    scrub_state_t st, st_nxt;
    logic         adv;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SC_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SC_OFF:  st_nxt = scrub_en ? SC_RD : SC_OFF;
            SC_RD:   begin
                if (!scrub_en)      st_nxt = SC_OFF;
                else if (!usr_busy) st_nxt = SC_CHK;
            end
            SC_CHK:  st_nxt = scrub_en ? SC_RD : SC_OFF;
            default: st_nxt = SC_OFF;
        endcase
    end

    always_comb begin
        scr_rd  = 1'b0;
        scr_wr  = 1'b0;
        scr_chk = 1'b0;
        adv     = 1'b0;
        unique case (st)
            SC_OFF: ;
            SC_RD:  scr_rd = scrub_en && !usr_busy;
            SC_CHK: begin
                scr_chk = 1'b1;
                scr_wr  = scrub_en && chk_sec && !usr_busy;
                adv     = scrub_en && (!chk_sec || !usr_busy);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   scr_addr <= '0;
        else if (adv) scr_addr <= scr_addr + 1'b1;
    end

    // R5: scrub memory cycles only in user-idle cycles
    p_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_rd || scr_wr) |-> !usr_busy);

    // R6: a write-back always follows the scrub read of the same word
    p_wb_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scr_wr |-> $past(scr_rd));

    // R6: the address steps by one, wrapping naturally
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_chk && scrub_en && !chk_sec) |=> scr_addr == ($past(scr_addr) + 1'b1));

    // R7: an abandoned write-back keeps the address for a retry
    p_retry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_chk && chk_sec && usr_busy) |=> $stable(scr_addr));

endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
    import ecc_scrub_pkg::*;
#(
    parameter  int DATA_W = 16,
    parameter  int ADDR_W = 6,
    parameter  int CNT_W  = 16,
    localparam int P      = ecc_hbits(DATA_W),
    localparam int CW_W   = DATA_W + P + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_we,
    input  logic              usr_re,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [CW_W-1:0]   usr_inj,
    input  logic              scrub_en,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rvalid,
    output logic              usr_sec,
    output logic              usr_ded,
    output logic              ue_pulse,
    output logic [CNT_W-1:0]  cnt_corr,
    output logic [CNT_W-1:0]  cnt_unc
);

    logic              usr_busy;
    logic [CW_W-1:0]   enc_cw, ram_q, fix_cw, ram_wdata;
    logic [ADDR_W-1:0] ram_addr, scr_addr;
    logic              ram_we, ram_re;
    logic              scr_rd, scr_wr, scr_chk;
    logic              dec_sec, dec_ded;
    logic              rd_user_q;

    assign usr_busy = usr_we || usr_re;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (usr_wdata),
        .cw   (enc_cw)
    );

    scrub_ctrl #(.ADDR_W(ADDR_W)) u_scrub (
        .clk      (clk),
        .rst_n    (rst_n),
        .scrub_en (scrub_en),
        .usr_busy (usr_busy),
        .chk_sec  (dec_sec),
        .scr_rd   (scr_rd),
        .scr_wr   (scr_wr),
        .scr_chk  (scr_chk),
        .scr_addr (scr_addr)
    );

    // Single port: the user owns every cycle it asks for.
    assign ram_we    = usr_we || scr_wr;
    assign ram_re    = (usr_re && !usr_we) || scr_rd;
    assign ram_addr  = usr_busy ? usr_addr : scr_addr;
    assign ram_wdata = usr_we ? (enc_cw ^ usr_inj) : fix_cw;

    ecc_ram_array #(.W(CW_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .cw_in  (ram_q),
        .cw_fix (fix_cw),
        .data   (usr_rdata),
        .sec    (dec_sec),
        .ded    (dec_ded)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rd_user_q <= 1'b0;
        else        rd_user_q <= usr_re && !usr_we;
    end

    assign usr_rvalid = rd_user_q;
    assign usr_sec    = rd_user_q && dec_sec;
    assign usr_ded    = rd_user_q && dec_ded;
    assign ue_pulse   = (rd_user_q || scr_chk) && dec_ded;

    sat_cnt #(.W(CNT_W)) u_cnt_corr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (usr_sec || scr_wr),
        .q     (cnt_corr)
    );

    sat_cnt #(.W(CNT_W)) u_cnt_unc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ue_pulse),
        .q     (cnt_unc)
    );

    // R1: a result appears exactly one cycle after a pure read request
    p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rvalid |-> $past(usr_re && !usr_we));

    // R4: a colliding read and write yields no read result
    p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_we && usr_re) |=> !usr_rvalid);

    // R5: the scrubber never reads under a user read result
    p_no_mix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(usr_rvalid && scr_chk));

    // R3: an uncorrectable pulse only accompanies an uncorrectable decode
    p_ue_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |-> !usr_sec);

endmodule

// File: tb/ecc_scrub_mem_bench.sv
`timescale 1ns/1ps
module ecc_scrub_mem_bench;

    localparam int DW   = 16;
    localparam int AW   = 3;
    localparam int CW   = 4;
    localparam int CWW  = 22;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usr_we = 1'b0, usr_re = 1'b0, scrub_en = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic [CWW-1:0] usr_inj = '0;
    logic [DW-1:0] usr_rdata;
    logic          usr_rvalid, usr_sec, usr_ded, ue_pulse;
    logic [CW-1:0] cnt_corr, cnt_unc;

    always #10 clk = ~clk;

    ecc_scrub_mem #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_ecc_scrub_mem (
        .clk(clk), .rst_n(rst_n), .usr_we(usr_we), .usr_re(usr_re),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .usr_inj(usr_inj),
        .scrub_en(scrub_en), .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid),
        .usr_sec(usr_sec), .usr_ded(usr_ded), .ue_pulse(ue_pulse),
        .cnt_corr(cnt_corr), .cnt_unc(cnt_unc)
    );

    typedef struct {
        logic [DW-1:0] data;
        logic          sec;
        logic          ded;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] model [8];
    int            n_chk = 0, n_bad = 0;
    int            exp_corr = 0, exp_unc = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // Monitor: pops expected results as the design produces them.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (usr_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected read result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (!e.ded) check(usr_rdata == e.data, {e.tag, " data"}, usr_rdata, e.data);
                    check(usr_sec == e.sec, {e.tag, " sec"}, usr_sec, e.sec);
                    check(usr_ded == e.ded, {e.tag, " ded"}, usr_ded, e.ded);
                    check(ue_pulse == e.ded, {e.tag, " ue_pulse"}, ue_pulse, e.ded);
                end
            end else if (ue_pulse) begin
                check(1'b0, "R3 stray ue_pulse", 1, 0);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            usr_we = 1'b0; usr_re = 1'b0; usr_inj = '0;
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input logic [CWW-1:0] m);
        @(negedge clk);
        usr_we = 1'b1; usr_re = 1'b0; usr_addr = AW'(a); usr_wdata = d; usr_inj = m;
        model[a] = d;
    endtask

    task automatic rd(input int a, input bit s, input bit dd, input string tag);
        exp_t e;
        @(negedge clk);
        usr_we = 1'b0; usr_re = 1'b1; usr_addr = AW'(a); usr_inj = '0;
        e.data = model[a]; e.sec = s; e.ded = dd; e.tag = tag;
        exp_q.push_back(e);
        if (s)  exp_corr = sat(exp_corr + 1);
        if (dd) exp_unc  = sat(exp_unc + 1);
    endtask

    task automatic chk_cnt(input string tag);
        idle(3);
        check(cnt_corr == CW'(exp_corr), {tag, " cnt_corr"}, cnt_corr, exp_corr);
        check(cnt_unc == CW'(exp_unc), {tag, " cnt_unc"}, cnt_unc, exp_unc);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int bits[4];
        bits = '{0, 1, 9, 21};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(usr_rvalid == 1'b0, "R10 rvalid", usr_rvalid, 0);
        check(ue_pulse == 1'b0, "R10 ue_pulse", ue_pulse, 0);
        check(cnt_corr == '0, "R10 cnt_corr", cnt_corr, 0);
        check(cnt_unc == '0, "R10 cnt_unc", cnt_unc, 0);

        // R1: several data patterns
        wr(0, 16'h0000, '0); wr(1, 16'hFFFF, '0); wr(2, 16'hA5A5, '0); wr(3, 16'h5A5A, '0);
        wr(4, 16'h8001, '0); wr(5, 16'h1234, '0); wr(6, 16'hFEDC, '0); wr(7, 16'h0F0F, '0);
        for (int a = 0; a < 8; a++) rd(a, 1'b0, 1'b0, "R1 clean read");
        idle(2);

        // R4: simultaneous write and read -> write only
        @(negedge clk);
        usr_we = 1'b1; usr_re = 1'b1; usr_addr = 3'd2; usr_wdata = 16'hC3C3; usr_inj = '0;
        model[2] = 16'hC3C3;
        idle(1);
        check(usr_rvalid == 1'b0, "R4 no result after collision", usr_rvalid, 0);
        rd(2, 1'b0, 1'b0, "R4 write took effect");
        idle(2);

        // R2: single flips at several codeword positions
        foreach (bits[i]) begin
            wr(3, 16'h3C00 ^ 16'(bits[i]), CWW'(1) << bits[i]);
            rd(3, 1'b1, 1'b0, "R2 single corrected");
        end
        wr(3, 16'h5A5A, '0);
        idle(1);

        // R3: double flip
        wr(6, 16'hBEEF, (CWW'(1) << 3) | (CWW'(1) << 12));
        rd(6, 1'b0, 1'b1, "R3 double detected");
        wr(6, 16'hFEDC, '0);
        chk_cnt("R9 after R2/R3");

        // R8: errors persist while scrub is off
        wr(5, 16'h1234, CWW'(1) << 7);
        wr(1, 16'hFFFF, CWW'(1) << 16);
        rd(5, 1'b1, 1'b0, "R2 addr5 single");
        idle(40);
        rd(5, 1'b1, 1'b0, "R8 error kept with scrub off");
        idle(2);

        // R7 / R5: alternating traffic makes every write-back collide
        @(negedge clk); scrub_en = 1'b1; usr_we = 1'b0; usr_re = 1'b0;
        for (int i = 0; i < 30; i++) begin
            idle(1);
            rd(0, 1'b0, 1'b0, "R5 user read under scrub");
        end
        @(negedge clk); scrub_en = 1'b0; usr_we = 1'b0; usr_re = 1'b0;
        idle(2);
        rd(5, 1'b1, 1'b0, "R7 write-back abandoned");
        chk_cnt("R7 no scrub count");

        // R6: idle scrub walks all addresses and repairs both words
        @(negedge clk); scrub_en = 1'b1; usr_we = 1'b0; usr_re = 1'b0;
        idle(40);
        @(negedge clk); scrub_en = 1'b0;
        idle(2);
        exp_corr = sat(exp_corr + 2);
        rd(5, 1'b0, 1'b0, "R6 addr5 repaired");
        rd(1, 1'b0, 1'b0, "R6 addr1 repaired");
        chk_cnt("R6/R9 scrub counted");

        // R9: saturation
        wr(4, 16'h8001, CWW'(1) << 11);
        for (int i = 0; i < 10; i++) rd(4, 1'b1, 1'b0, "R9 repeated correction");
        chk_cnt("R9 saturated");
        check(cnt_corr == CW'(CMAX), "R9 saturation value", cnt_corr, CMAX);

        idle(3);
        check(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule